// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

This block gathers interrupt requests from a small set of peripheral sources and presents one interrupt request line, plus the number of the chosen source, to a CPU. Each source owns a 3-bit urgency level; a lower number is more urgent, and the all-ones value switches the source off. A source is either edge-type, where a rising request is caught in a pending flip-flop that software or an acknowledge can clear, or level-type, where the pending bit simply mirrors the live request and cannot be written.

Each cycle the controller looks at every enabled pending source and picks the one with the lowest level. When levels are equal, the lowest source index wins. That level is then compared with a 3-bit mask held in a register. The request line is raised only when the mask is strictly above the winning level. The request line and vector come from registers, and so they trail the register state by one clock. An acknowledge strobe stands for the CPU's read of the vector. It clears the pending flip-flop of the source currently shown, when that source is edge-type.

Software reaches the controller through a flat register port. Address k holds the pair of sources 2k and 2k+1. Address NUM_SRC/2 holds the mask.

Top module: `lvl_intc`

## Requirements
- R1: After reset, cpu_irq is 0. Every level field reads 7 and every pending bit reads 0. The mask reads 0. An edge-type request that is already high at reset does not count as an edge.
- R2: A source whose level is 7 never causes cpu_irq, whatever the mask.
- R3: With a single enabled pending source at level L, cpu_irq is 1 exactly when mask > L. Mask 0 blocks everything.
- R4: Among enabled pending sources, cpu_vec names the one with the lowest level, and the lowest index when levels tie. cpu_irq is only raised for a pending source.
- R5: A 0-to-1 transition on the request of an edge-type source sets its pending bit. The bit stays set after the request falls.
- R6: A register write with 0 in an edge-type source's pending position clears that bit. A write with 1 there leaves the bit unchanged.
- R7: The pending bit of a level-type source reads as its live request. Register writes and acknowledges do not change it.
- R8: vec_ack clears the pending flip-flop of the edge-type source named by cpu_vec. cpu_irq then falls one clock later when no other source qualifies.
- R9: Register layout. The word at address k holds source 2k with its pending bit at bit 3 and its level at bits 7:5, and source 2k+1 with its pending bit at bit 11 and its level at bits 15:13. The mask sits at bits 2:0 of address NUM_SRC/2. All other read bits are 0.
- R10: cpu_irq and cpu_vec are registered. After a write that changes the mask, cpu_irq keeps its old value for one clock and shows the new value after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NUM_SRC | Peripheral request lines, one per source |
| reg_addr | input | ADDR_W | Register address (pairs, then mask) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| vec_ack | input | 1 | Vector read acknowledge from the CPU |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| cpu_vec | output | SRC_W | Number of the winning source |

## Verification
A pending flip-flop that is stuck or wrongly cleared shows up in the pending bit of the register read in the same cycle. It shows up on cpu_irq or cpu_vec one clock later. A fault in the arbiter or the mask compare shows up as a wrong cpu_vec or a wrong cpu_irq exactly one edge after the levels or mask settle. For that reason the bench sweeps every level against every mask, and many level patterns across four sources, and checks the outputs at that edge. A bad acknowledge or write-clear path leaves a bit set that should read 0 right after the strobe.

// File: rtl/lvl_intc_pkg.sv
package lvl_intc_pkg;
  localparam int LVL_W    = 3;
  localparam int HALF_W   = 8;
  localparam int PEND_POS = 3;
  localparam int LVL_POS  = 5;
  localparam int DATA_W   = 16;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_OFF = '1;
endpackage

// File: rtl/lvl_intc_src.sv
module lvl_intc_src #(
  parameter bit EDGE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic wr_clr,
  input  logic ack_clr,
  output logic pend
);
  generate
    if (EDGE) begin : g_edge
      logic req_d_q;
      logic pend_q;
      logic pend_nxt;
      logic rise;

      assign rise = req & ~req_d_q;

      always_comb begin
        pend_nxt = pend_q;
        if (wr_clr || ack_clr) pend_nxt = 1'b0;
        if (rise) pend_nxt = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          req_d_q <= 1'b1;
          pend_q  <= 1'b0;
        end else begin
          req_d_q <= req;
          pend_q  <= pend_nxt;
        end
      end

      assign pend = pend_q;
    end else begin : g_level
      logic unused_in;
      assign unused_in = ^{clk, rst_n, wr_clr, ack_clr};
      assign pend = req;
    end
  endgenerate
endmodule

// File: rtl/lvl_intc_arb.sv
module lvl_intc_arb
  import lvl_intc_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int SRC_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]       pend,
  input  logic [NUM_SRC*LVL_W-1:0] lvl_flat,
  output logic                     win_vld,
  output logic [SRC_W-1:0]         win_idx,
  output lvl_t                     win_lvl
);
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    win_lvl = LVL_OFF;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend[i] && (lvl_flat[i*LVL_W +: LVL_W] != LVL_OFF) &&
          (!win_vld || (lvl_flat[i*LVL_W +: LVL_W] < win_lvl))) begin
        win_vld = 1'b1;
        win_idx = SRC_W'(i);
        win_lvl = lvl_flat[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/lvl_intc.sv
module lvl_intc
  import lvl_intc_pkg::*;
#(
  parameter int               NUM_SRC  = 4,
  parameter logic [NUM_SRC-1:0] EDGE_MAP = 4'b0011,
  parameter int               SRC_W    = $clog2(NUM_SRC),
  parameter int               ADDR_W   = $clog2(NUM_SRC/2 + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [15:0]        reg_wdata,
  output logic [15:0]        reg_rdata,
  input  logic               vec_ack,
  output logic               cpu_irq,
  output logic [SRC_W-1:0]   cpu_vec
);
  localparam int NUM_PAIR = NUM_SRC / 2;
  localparam int MASK_SEL = NUM_PAIR;

  logic [NUM_SRC-1:0]       pend;
  logic [NUM_SRC*LVL_W-1:0] lvl_flat;
  lvl_t                     mask_q;
  lvl_t                     mask_nxt;
  logic                     mask_we;
  logic                     win_vld;
  logic [SRC_W-1:0]         win_idx;
  lvl_t                     win_lvl;
  logic                     irq_q;
  logic                     irq_nxt;
  logic [SRC_W-1:0]         vec_q;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      localparam int PAIR = i / 2;
      localparam int BASE = (i % 2) * HALF_W;
      logic pair_sel;
      logic lvl_we;
      lvl_t lvl_q;
      lvl_t lvl_nxt;
      logic wr_clr;
      logic ack_clr;

      assign pair_sel = reg_wr && (int'(reg_addr) == PAIR);
      assign lvl_we   = pair_sel;
      assign lvl_nxt  = reg_wdata[BASE+LVL_POS +: LVL_W];
      assign wr_clr   = pair_sel && !reg_wdata[BASE+PEND_POS];
      assign ack_clr  = vec_ack && (int'(vec_q) == i);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= LVL_OFF;
        else if (lvl_we) lvl_q <= lvl_nxt;
      end

      assign lvl_flat[i*LVL_W +: LVL_W] = lvl_q;

      lvl_intc_src #(.EDGE(EDGE_MAP[i])) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (src_req[i]),
        .wr_clr  (wr_clr),
        .ack_clr (ack_clr),
        .pend    (pend[i])
      );
    end
  endgenerate

  assign mask_we  = reg_wr && (int'(reg_addr) == MASK_SEL);
  assign mask_nxt = reg_wdata[LVL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (mask_we) mask_q <= mask_nxt;
  end

  lvl_intc_arb #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_arb (
    .pend     (pend),
    .lvl_flat (lvl_flat),
    .win_vld  (win_vld),
    .win_idx  (win_idx),
    .win_lvl  (win_lvl)
  );

  assign irq_nxt = win_vld && (mask_q > win_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= irq_nxt;
      vec_q <= win_idx;
    end
  end

  assign cpu_irq = irq_q;
  assign cpu_vec = vec_q;

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (int'(reg_addr) == i / 2) begin
        reg_rdata[(i%2)*HALF_W + PEND_POS] = pend[i];
        reg_rdata[(i%2)*HALF_W + LVL_POS +: LVL_W] = lvl_flat[i*LVL_W +: LVL_W];
      end
    end
    if (int'(reg_addr) == MASK_SEL) reg_rdata[LVL_W-1:0] = mask_q;
  end
endmodule

// File: rtl/lvl_intc_chk.sv
module lvl_intc_chk
  import lvl_intc_pkg::*;
#(
  parameter int                 NUM_SRC  = 4,
  parameter logic [NUM_SRC-1:0] EDGE_MAP = 4'b0011,
  parameter int                 SRC_W    = $clog2(NUM_SRC)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_SRC-1:0]       src_req,
  input logic                     vec_ack,
  input logic                     cpu_irq,
  input logic [SRC_W-1:0]         cpu_vec,
  input logic [LVL_W-1:0]         mask_q,
  input logic [NUM_SRC*LVL_W-1:0] lvl_flat,
  input logic [NUM_SRC-1:0]       pend
);
  logic [LVL_W-1:0]         mask_p;
  logic [NUM_SRC*LVL_W-1:0] lvl_p;
  logic [NUM_SRC-1:0]       pend_p;
  logic [NUM_SRC-1:0]       req_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_p <= '0;
      lvl_p  <= '1;
      pend_p <= '0;
      req_p  <= '1;
    end else begin
      mask_p <= mask_q;
      lvl_p  <= lvl_flat;
      pend_p <= pend;
      req_p  <= src_req;
    end
  end

  AST_IRQ_MASK_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (mask_p > lvl_p[int'(cpu_vec)*LVL_W +: LVL_W])); // R3
  AST_IRQ_NOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (lvl_p[int'(cpu_vec)*LVL_W +: LVL_W] != LVL_OFF)); // R2
  AST_IRQ_WIN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> pend_p[cpu_vec]); // R4

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
      if (EDGE_MAP[i]) begin : g_edge
        AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
          (src_req[i] && !req_p[i]) |=> pend[i]); // R5
        AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
          (vec_ack && (int'(cpu_vec) == i) && !(src_req[i] && !req_p[i])) |=> !pend[i]); // R8
      end
    end
  endgenerate
endmodule

bind lvl_intc lvl_intc_chk #(.NUM_SRC(NUM_SRC), .EDGE_MAP(EDGE_MAP), .SRC_W(SRC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .src_req  (src_req),
  .vec_ack  (vec_ack),
  .cpu_irq  (cpu_irq),
  .cpu_vec  (cpu_vec),
  .mask_q   (mask_q),
  .lvl_flat (lvl_flat),
  .pend     (pend)
);

// File: tb/lvl_intc_tb_top.sv
module lvl_intc_tb_top;
  localparam int NS = 4;

  logic        clk;
  logic        rst_n;
  logic [3:0]  src_req;
  logic [1:0]  reg_addr;
  logic        reg_wr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        vec_ack;
  logic        cpu_irq;
  logic [1:0]  cpu_vec;

  int n_chk;
  int n_err;
  bit done;

  lvl_intc #(.NUM_SRC(NS), .EDGE_MAP(4'b0011)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .vec_ack(vec_ack), .cpu_irq(cpu_irq), .cpu_vec(cpu_vec)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] half(input int lvl, input bit p);
    return {lvl[2:0], 1'b0, p, 3'b000};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    reg_addr  = a[1:0];
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    reg_addr = a[1:0];
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input int i);
    src_req[i] = 1'b1;
    @(negedge clk);
    src_req[i] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] d;
    int lv [4];
    int vals [4];
    n_chk = 0; n_err = 0; done = 0;
    vals[0] = 0; vals[1] = 2; vals[2] = 4; vals[3] = 7;
    rst_n = 1'b0; src_req = 4'b0001; reg_addr = '0; reg_wr = 0;
    reg_wdata = '0; vec_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state; request high through reset is no edge
    chk("R1 irq", cpu_irq, 0);
    rd(0, d); chk("R1 word0", d, 16'hE0E0);
    rd(1, d); chk("R1 word1", d, 16'hE0E0);
    rd(2, d); chk("R1 mask", d, 0);
    src_req = 4'b0000;
    @(negedge clk);

    // R2 R3 exhaustive mask x level on level-type source 2
    src_req[2] = 1'b1;
    for (int l = 0; l < 8; l++) begin
      wr(1, {half(7, 0), half(l, 0)});
      for (int m = 0; m < 8; m++) begin
        wr(2, 16'(m));
        @(negedge clk);
        chk((l == 7) ? "R2 off" : "R3 mask", cpu_irq, (m > l) ? 1 : 0);
        if (m > l) chk("R3 vec", cpu_vec, 2);
      end
    end
    // R9 mask readback
    wr(2, 16'hFFF5);
    rd(2, d); chk("R9 mask bits", d, 5);

    // R7 level source follows request, ignores writes and acks
    wr(1, {half(7, 0), half(2, 0)});
    rd(1, d); chk("R7 pend follows", d[3], 1);
    chk("R9 level field", d[7:5], 2);
    vec_ack = 1'b1; @(negedge clk); vec_ack = 1'b0;
    rd(1, d); chk("R7 ack ignored", d[3], 1);
    src_req[2] = 1'b0; #1;
    rd(1, d); chk("R7 pend drops", d[3], 0);
    wr(1, {half(7, 1), half(7, 1)});
    rd(1, d); chk("R7 write ignored", d[3], 0);

    // R5 edge latch on source 1 (high half of word0)
    wr(2, 16'd7);
    wr(0, {half(1, 0), half(7, 0)});
    pulse(1);
    rd(0, d); chk("R5 latched bit11", d[11], 1);
    chk("R9 level bits15:13", d[15:13], 1);
    chk("R5 irq", cpu_irq, 1);
    chk("R5 vec", cpu_vec, 1);
    // R10 mask lowered to level: irq holds one clock, then drops
    wr(2, 16'd1);
    chk("R10 irq holds", cpu_irq, 1);
    @(negedge clk);
    chk("R10 irq drops", cpu_irq, 0);
    wr(2, 16'd7);
    @(negedge clk);
    chk("R10 irq back", cpu_irq, 1);
    // R6 write 1 keeps, write 0 clears, write 1 does not set
    wr(0, {half(1, 1), half(7, 1)});
    rd(0, d); chk("R6 write1 keeps", d[11], 1);
    wr(0, {half(1, 0), half(7, 1)});
    rd(0, d); chk("R6 write0 clears", d[11], 0);
    wr(0, {half(1, 1), half(7, 1)});
    @(negedge clk);
    rd(0, d); chk("R6 write1 no set", d[11], 0);
    chk("R6 irq stays low", cpu_irq, 0);
    // R8 acknowledge clears edge winner
    pulse(1);
    chk("R8 irq before ack", cpu_irq, 1);
    vec_ack = 1'b1; @(negedge clk); vec_ack = 1'b0;
    rd(0, d); chk("R8 pend cleared", d[11], 0);
    chk("R8 irq one clock", cpu_irq, 1);
    @(negedge clk);
    chk("R8 irq dropped", cpu_irq, 0);

    // R4 priority sweep over 4 sources, all pending
    pulse(0); pulse(1);
    src_req[3:2] = 2'b11;
    for (int c = 0; c < 256; c++) begin
      int best; int bi;
      for (int k = 0; k < 4; k++) lv[k] = vals[(c >> (2*k)) & 3];
      wr(0, {half(lv[1], 1), half(lv[0], 1)});
      wr(1, {half(lv[3], 0), half(lv[2], 0)});
      @(negedge clk);
      best = 7; bi = -1;
      for (int k = 0; k < 4; k++)
        if (lv[k] < best) begin best = lv[k]; bi = k; end
      chk("R4 irq", cpu_irq, (bi >= 0) ? 1 : 0);
      if (bi >= 0) chk("R4 vec", cpu_vec, bi);
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule